// File: doc/BRIEF.md
# Serial-Configured Clock Fan-Out Enable Controller

This block drives eighteen copies of one source clock. Each copy can be switched on or off by a bit in a small set of configuration registers, which a write-only two-wire serial slave loads. A faster system clock oversamples the serial clock and data lines through two-flop synchronizers. The block finds START and STOP conditions, takes data on rising serial-clock edges, checks the address byte and acknowledges each byte of an addressed transaction.

A configuration write is a fixed frame of ten bytes: the address byte, two header bytes whose values are ignored, and seven data bytes. The position of a data byte in the frame picks the register it loads; there is no register address. Only the first three data bytes carry enable bits. An external enable pin sits above the registers and puts every output into its high-impedance state when it is low.

Top module: `clk_fanout_ctrl`

## Requirements
- R1: After reset all eighteen enable bits are 1 and the serial data pull-down (`sda_pull_o`) is released (0).
- R2: A transaction whose first byte after START is 8'b11010010 (8'hD2) is acknowledged: `sda_pull_o` is 1 during the ninth serial clock of every byte of that transaction.
- R3: When the first byte after START is not 8'hD2, no byte of that transaction is acknowledged and no enable bit changes until the next START.
- R4: Frame positions 1 and 2 (the two header bytes after the address) are acknowledged, but their values change no enable bit.
- R5: Frame position 3 sets outputs 0 to 7 from bits 0 to 7, position 4 sets outputs 8 to 15 from bits 0 to 7, and position 5 sets outputs 16 and 17 from bits 0 and 1; bits 2 to 7 of position 5 are ignored. A bit of 1 enables the output.
- R6: Frame positions 6 to 9 are acknowledged and change no enable bit.
- R7: Each data byte is stored when its acknowledge clock ends, so a frame cut short by STOP keeps the bytes already received.
- R8: `out_oe_o` is all ones while `oe_pin_i` is 1 and all zeros while it is 0, whatever the register contents.
- R9: An enabled output follows `clk_src_i`; a disabled output is held at 0.
- R10: A repeated START aborts the frame in progress, and the next byte is taken as a new address byte at position 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial lines |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Serial clock line as seen at the pad |
| sda_i | input | 1 | Serial data line as seen at the pad |
| sda_pull_o | output | 1 | 1 pulls the serial data line low (acknowledge) |
| oe_pin_i | input | 1 | External output enable, low puts all outputs in high impedance (pulled up at the pad) |
| clk_src_i | input | 1 | Source clock to be fanned out |
| clk_out_o | output | 18 | Per-output clock value, gated by its enable bit |
| out_oe_o | output | 18 | Per-output driver enable, 0 means high impedance |

## Verification
The bench builds the block with its default parameters: eighteen outputs, the 8'hD2 address, a ten-byte frame and two-stage synchronizers. These values put all three enable lanes within reach, including the partial top lane, where only two of the eight bits are stored. With the default frame length, the trailing don't-care positions and an early STOP can both be driven. A serial bit period of forty system clocks leaves room for the synchronizer latency, so acknowledge timing and repeated START sit well inside each bit.

// File: rtl/clkfo_pkg.sv
package clkfo_pkg;

    localparam int NUM_OUT     = 18;
    localparam int FRAME_BYTES = 10;
    localparam int HDR_BYTES   = 3;
    localparam int IDX_W       = 4;
    localparam logic [7:0] DEV_ADDR = 8'hD2;

    typedef enum logic [1:0] {
        RX_IDLE   = 2'd0,
        RX_SHIFT  = 2'd1,
        RX_ACK    = 2'd2,
        RX_IGNORE = 2'd3
    } rx_state_e;

    typedef struct packed {
        logic             valid;
        logic [IDX_W-1:0] pos;
        logic [7:0]       data;
    } byte_evt_t;

    function automatic int lane_count(input int n_out);
        return (n_out + 7) / 8;
    endfunction

    function automatic int lane_width(input int n_out, input int lane);
        int rem;
        rem = n_out - lane * 8;
        return (rem > 8) ? 8 : rem;
    endfunction

endpackage

// File: rtl/clkfo_sync.sv
module clkfo_sync #(
    parameter int   WIDTH  = 2,
    parameter int   STAGES = 2,
    parameter logic INIT   = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) begin
                chain[s] <= {WIDTH{INIT}};
            end else if (s == 0) begin
                chain[s] <= d_i;
            end else begin
                chain[s] <= chain[(s == 0) ? 0 : s-1];
            end
        end
    end

    assign q_o = chain[STAGES-1];
endmodule

// File: rtl/clkfo_serial_rx.sv
module clkfo_serial_rx
    import clkfo_pkg::*;
#(
    parameter logic [7:0] ADDR   = DEV_ADDR,
    parameter int         FRAMES = FRAME_BYTES
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      scl_s,
    input  logic      sda_s,
    output logic      sda_pull,
    output byte_evt_t evt
);
    localparam logic [IDX_W-1:0] POS_MAX = IDX_W'((1 << IDX_W) - 1);

    rx_state_e        state;
    logic             scl_q, sda_q;
    logic [3:0]       bit_cnt;
    logic [7:0]       shreg;
    logic [IDX_W-1:0] pos;

    logic scl_rise, scl_fall, start_c, stop_c;
    assign scl_rise = scl_s & ~scl_q;
    assign scl_fall = ~scl_s & scl_q;
    assign start_c  = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_c   = scl_s & scl_q & ~sda_q & sda_s;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= RX_IDLE;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
            bit_cnt  <= '0;
            shreg    <= '0;
            pos      <= '0;
            sda_pull <= 1'b0;
            evt      <= '0;
        end else begin
            scl_q     <= scl_s;
            sda_q     <= sda_s;
            evt.valid <= 1'b0;
            if (start_c) begin
                state    <= RX_SHIFT;
                bit_cnt  <= '0;
                pos      <= '0;
                sda_pull <= 1'b0;
            end else if (stop_c) begin
                state    <= RX_IDLE;
                sda_pull <= 1'b0;
            end else begin
                unique case (state)
                    RX_SHIFT: begin
                        if (scl_rise && bit_cnt < 4'd8) begin
                            shreg   <= {shreg[6:0], sda_s};
                            bit_cnt <= bit_cnt + 4'd1;
                        end else if (scl_fall && bit_cnt == 4'd8) begin
                            if (pos == '0 && shreg != ADDR) begin
                                state <= RX_IGNORE;
                            end else begin
                                state    <= RX_ACK;
                                sda_pull <= 1'b1;
                            end
                        end
                    end
                    RX_ACK: begin
                        if (scl_fall) begin
                            sda_pull  <= 1'b0;
                            state     <= RX_SHIFT;
                            bit_cnt   <= '0;
                            evt.valid <= 1'b1;
                            evt.pos   <= pos;
                            evt.data  <= shreg;
                            if (pos != POS_MAX) pos <= pos + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    // R3: a rejected transaction neither acknowledges nor emits bytes
    p_ignore_quiet_r3: assert property (@(posedge clk) disable iff (rst)
        state == RX_IGNORE |-> !sda_pull && !evt.valid);

    // R2: the data line is only pulled during an acknowledge clock
    p_pull_in_ack_r2: assert property (@(posedge clk) disable iff (rst)
        sda_pull |-> state == RX_ACK);

    // R10: a START always restarts the frame at position 0
    p_start_restart_r10: assert property (@(posedge clk) disable iff (rst)
        start_c |=> state == RX_SHIFT && pos == '0 && bit_cnt == '0);

    logic unused_frames;
    assign unused_frames = (FRAMES > 0);
endmodule

// File: rtl/clkfo_enable_regs.sv
module clkfo_enable_regs
    import clkfo_pkg::*;
#(
    parameter int N_OUT = NUM_OUT,
    parameter int HDR   = HDR_BYTES
) (
    input  logic             clk,
    input  logic             rst,
    input  byte_evt_t        evt,
    output logic [N_OUT-1:0] en
);
    localparam int LANES = lane_count(N_OUT);

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        localparam int LO = l * 8;
        localparam int W  = lane_width(N_OUT, l);
        logic [W-1:0] lane_q;
        logic         hit;

        assign hit = evt.valid && (evt.pos == IDX_W'(HDR + l));

        always_ff @(posedge clk) begin
            if (rst)      lane_q <= '1;
            else if (hit) lane_q <= evt.data[W-1:0];
        end

        assign en[LO +: W] = lane_q;
    end

    // R4: header positions leave the enables alone
    p_hdr_ignored_r4: assert property (@(posedge clk) disable iff (rst)
        evt.valid && (int'(evt.pos) < HDR) |=> $stable(en));

    // R6: trailing don't-care positions leave the enables alone
    p_tail_ignored_r6: assert property (@(posedge clk) disable iff (rst)
        evt.valid && (int'(evt.pos) >= HDR + LANES) |=> $stable(en));
endmodule

// File: rtl/clk_fanout_ctrl.sv
module clk_fanout_ctrl
    import clkfo_pkg::*;
#(
    parameter int         N_OUT       = NUM_OUT,
    parameter int         SYNC_STAGES = 2,
    parameter logic [7:0] ADDR        = DEV_ADDR
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             scl_i,
    input  logic             sda_i,
    output logic             sda_pull_o,
    input  logic             oe_pin_i,
    input  logic             clk_src_i,
    output logic [N_OUT-1:0] clk_out_o,
    output logic [N_OUT-1:0] out_oe_o
);
    logic [1:0]       lines_s;
    byte_evt_t        evt;
    logic [N_OUT-1:0] en;

    clkfo_sync #(.WIDTH(2), .STAGES(SYNC_STAGES), .INIT(1'b1)) u_sync (
        .clk (clk),
        .rst (rst),
        .d_i ({scl_i, sda_i}),
        .q_o (lines_s)
    );

    clkfo_serial_rx #(.ADDR(ADDR), .FRAMES(FRAME_BYTES)) u_rx (
        .clk      (clk),
        .rst      (rst),
        .scl_s    (lines_s[1]),
        .sda_s    (lines_s[0]),
        .sda_pull (sda_pull_o),
        .evt      (evt)
    );

    clkfo_enable_regs #(.N_OUT(N_OUT), .HDR(HDR_BYTES)) u_regs (
        .clk (clk),
        .rst (rst),
        .evt (evt),
        .en  (en)
    );

    assign clk_out_o = {N_OUT{clk_src_i}} & en;
    assign out_oe_o  = {N_OUT{oe_pin_i}};

    // R1: the data line is never pulled in the cycle after reset
    p_release_after_reset_r1: assert property (@(posedge clk)
        $fell(rst) |-> !sda_pull_o);
endmodule

// File: tb/tb_clk_fanout_ctrl.sv
`timescale 1ns/1ps
module tb_clk_fanout_ctrl;
    localparam int N = 18;
    localparam int Q = 10;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic oe_pin = 1'b1, clk_src = 1'b1;
    logic sda_pull;
    logic [N-1:0] clk_out, out_oe;
    logic sda_bus;

    assign sda_bus = m_sda & ~sda_pull;

    clk_fanout_ctrl dut (
        .clk(clk), .rst(rst), .scl_i(m_scl), .sda_i(sda_bus),
        .sda_pull_o(sda_pull), .oe_pin_i(oe_pin), .clk_src_i(clk_src),
        .clk_out_o(clk_out), .out_oe_o(out_oe)
    );

    always #5 clk = ~clk;

    int tests = 0, fails = 0;
    int oe_bad = 0, gate_bad = 0;
    bit quiet = 1'b0, done = 1'b0;
    logic [N-1:0] exp_en;
    int pos_m;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // reference model: map a frame position and value onto enable bits
    task automatic model_byte(input int p, input logic [7:0] b);
        for (int k = 0; k < N; k++)
            if (p >= 3 && k / 8 == p - 3) exp_en[k] = b[k % 8];
    endtask

    task automatic w(input int n); repeat (n) @(posedge clk); endtask

    task automatic bus_start();
        m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q);
        m_sda = 1'b0; w(Q); m_scl = 1'b0; w(Q);
        pos_m = 0;
    endtask

    task automatic bus_stop();
        m_sda = 1'b0; w(Q); m_scl = 1'b1; w(Q); m_sda = 1'b1; w(Q);
    endtask

    task automatic send(input logic [7:0] b, input bit addressed, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_sda = b[i]; w(Q); m_scl = 1'b1; w(2*Q); m_scl = 1'b0; w(Q);
        end
        m_sda = 1'b1; w(Q); m_scl = 1'b1; w(Q);
        @(negedge clk); ack = !sda_bus;
        w(Q); m_scl = 1'b0; w(Q);
        if (addressed) model_byte(pos_m, b);
        pos_m++;
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (!rst) begin
            if (out_oe !== {N{oe_pin}}) oe_bad++;
            if (quiet && clk_out !== ({N{clk_src}} & exp_en)) gate_bad++;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++; tests++;
            $display("FAIL watchdog actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    bit a;
    initial begin
        logic [7:0] fr [10];
        exp_en = '1;
        w(4); rst = 1'b0; w(4);
        @(negedge clk);
        chk("R1 enables after reset", 32'(clk_out), 32'({N{1'b1}}));
        chk("R1 pull released", 32'(sda_pull), 32'd0);
        quiet = 1'b1;

        // full frame
        fr = '{8'hD2, 8'hA5, 8'h3C, 8'h5A, 8'hC3, 8'hFE, 8'h00, 8'h00, 8'h00, 8'h00};
        quiet = 1'b0; bus_start();
        for (int i = 0; i < 10; i++) begin
            send(fr[i], 1'b1, a);
            if (i == 0)      chk("R2 address ack", 32'(a), 32'd1);
            else if (i < 3)  chk("R4 header ack", 32'(a), 32'd1);
            else if (i >= 6) chk("R6 tail ack", 32'(a), 32'd1);
        end
        bus_stop(); quiet = 1'b1; @(negedge clk);
        chk("R5 lane mapping", 32'(clk_out), 32'({2'b10, 8'hC3, 8'h5A}));
        chk("R4 R6 model agrees", 32'(exp_en), 32'({2'b10, 8'hC3, 8'h5A}));

        // wrong address
        quiet = 1'b0; bus_start();
        send(8'hD4, 1'b0, a);
        chk("R3 no ack on address", 32'(a), 32'd0);
        for (int i = 1; i < 10; i++) begin
            send(8'h00, 1'b0, a);
            if (i == 3) chk("R3 no ack on data", 32'(a), 32'd0);
        end
        bus_stop(); quiet = 1'b1; @(negedge clk);
        chk("R3 enables unchanged", 32'(clk_out), 32'({2'b10, 8'hC3, 8'h5A}));

        // early stop after first data byte
        quiet = 1'b0; bus_start();
        send(8'hD2, 1'b1, a); send(8'h11, 1'b1, a); send(8'h22, 1'b1, a);
        send(8'hFF, 1'b1, a);
        bus_stop(); quiet = 1'b1; @(negedge clk);
        chk("R7 partial frame kept", 32'(clk_out), 32'({2'b10, 8'hC3, 8'hFF}));

        // repeated start mid-frame
        quiet = 1'b0; bus_start();
        send(8'hD2, 1'b1, a); send(8'h00, 1'b1, a);
        bus_start();
        send(8'hD2, 1'b1, a);
        chk("R10 new address acked", 32'(a), 32'd1);
        send(8'h00, 1'b1, a); send(8'h00, 1'b1, a);
        send(8'h00, 1'b1, a); send(8'h00, 1'b1, a); send(8'h03, 1'b1, a);
        bus_stop(); quiet = 1'b1; @(negedge clk);
        chk("R10 positions restarted", 32'(clk_out), 32'({2'b11, 8'h00, 8'h00}));

        // clock follow and gating
        clk_src = 1'b0; w(3); @(negedge clk);
        chk("R9 low source", 32'(clk_out), 32'd0);
        for (int t = 0; t < 6; t++) begin clk_src = ~clk_src; w(2); end
        clk_src = 1'b1; w(2); @(negedge clk);
        chk("R9 high source gated", 32'(clk_out), 32'({2'b11, 16'h0000}));

        // output enable pin
        oe_pin = 1'b0; w(3); @(negedge clk);
        chk("R8 pin low", 32'(out_oe), 32'd0);
        oe_pin = 1'b1; w(3); @(negedge clk);
        chk("R8 pin high", 32'(out_oe), 32'({N{1'b1}}));

        chk("R8 per-cycle oe", 32'(oe_bad), 32'd0);
        chk("R9 per-cycle gating", 32'(gate_bad), 32'd0);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule